// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a single-master controller for a two-wire serial bus with open-drain lines. It never drives a line high: each of its two line outputs is an enable that pulls the wire low when set and releases it when clear, and the pull-up resistors supply the high level. It reads both wires back, so it can see the wired-AND level that results from every device on the bus.

A simple command port with a valid/ready handshake accepts four operations. START produces the opening condition. WRITE shifts out one byte and samples the target's acknowledge. READ shifts in one byte and answers it with ACK or NACK. STOP produces the closing condition. Each command ends with a one-cycle `done` pulse. Every bit takes four quarter phases, and the length of one quarter, in clock cycles, is set at an input, so the bus rate can be changed between commands. While it releases SDA, the controller compares the level it reads back with the high level it expects. If a low is seen at the sample point, another master has taken the bus. The controller then lets go of both lines at once and reports the loss.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset and after a STOP completes, `scl_oe` and `sda_oe` are both 0 (both lines released), `cmd_ready` is 1, `busy` is 0 and `done` is 0.
- R2: START (`cmd_op` = 2'b00) takes 4 quarters. It releases SDA and then SCL, pulls SDA low while SCL is released, and finally pulls SCL low.
- R3: STOP (`cmd_op` = 2'b11) takes 4 quarters. It pulls SDA and SCL low, releases SCL, and then releases SDA while SCL is released, which leaves the bus idle.
- R4: During WRITE and READ, SDA changes only while SCL is pulled low. It stays constant while SCL is high.
- R5: WRITE (`cmd_op` = 2'b01) sends `cmd_wdata` most significant bit first over 8 SCL pulses and adds a ninth acknowledge pulse. The whole byte takes 36 quarters and ends with SCL held low.
- R6: On the ninth pulse of a WRITE, SDA is released and sampled. `ack_nack` then shows the sampled level (0 = ACK, 1 = NACK) and holds it until the next WRITE.
- R7: READ (`cmd_op` = 2'b10) samples 8 bits, most significant bit first, at the middle of each SCL high phase. The byte appears on `rdata` in the cycle of `done`. `rdata` changes at no other time.
- R8: On the ninth pulse of a READ, SDA is pulled low when `cmd_rd_nack` was 0 (ACK) and released when it was 1 (NACK).
- R9: When SDA is sampled low at a point where the controller had released it (a WRITE data bit of 1, a READ NACK, or the STOP release), `arb_lost` is set, both lines are released in the same cycle, `done` pulses and the command ends. `arb_lost` is cleared when the next command is accepted.
- R10: Each quarter phase lasts `quarter_div` clock cycles. A value of 0 acts as 1.
- R11: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 and `busy` is 1 until the command ends, and `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quarter_div | input | DIVW | Clock cycles per quarter SCL phase |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 2 | 00 START, 01 WRITE, 10 READ, 11 STOP |
| cmd_wdata | input | 8 | Byte to send on WRITE |
| cmd_rd_nack | input | 1 | READ answer: 0 ACK, 1 NACK |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| ack_nack | output | 1 | Acknowledge level sampled on the last WRITE |
| rdata | output | 8 | Byte from the last READ |
| arb_lost | output | 1 | Arbitration lost on the last command |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | SCL level read back |
| sda_in | input | 1 | SDA level read back |

## Verification
The bench builds the controller with `DIVW` = 4. It runs the quarter length at 1, 2 and 3 cycles, so each command's cycle count shows how the divider scales the timing, and the single-cycle quarter shows the tightest setup of SDA before SCL rises. A target model on the wired-AND bus acknowledges or ignores writes, sends read bytes and stops after a NACK. It can also pull SDA low at a chosen bit, which makes arbitration loss occur in the middle of a byte.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] quarter_div,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [7:0]      cmd_wdata,
  input  logic            cmd_rd_nack,
  output logic            busy,
  output logic            done,
  output logic            ack_nack,
  output logic [7:0]      rdata,
  output logic            arb_lost,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic            scl_in,
  input  logic            sda_in
);

  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_STOP  = 2'b11;

  logic            run;
  logic [1:0]      op;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic [DIVW-1:0] dcnt;
  logic [7:0]      wbuf;
  logic [7:0]      shf;
  logic            rnack;

  function automatic logic sda_drive(input logic [1:0] o, input logic [7:0] d,
                                     input logic nk, input logic [3:0] i);
    if (o == OP_WR) return (i < 4'd8) ? ~d[3'd7 - i[2:0]] : 1'b0;
    if (o == OP_RD) return (i < 4'd8) ? 1'b0 : ~nk;
    return 1'b0;
  endfunction

  wire [DIVW-1:0] dlim    = (quarter_div == '0) ? DIVW'(1) : quarter_div;
  wire            qtick   = run && (dcnt == dlim - DIVW'(1));
  wire            data_op = (op == OP_WR) || (op == OP_RD);
  wire            last_q  = (q == 2'd3) && (!data_op || bitn == 4'd8);
  wire [1:0]      nq      = q + 2'd1;
  wire [3:0]      nb      = (q == 2'd3) ? bitn + 4'd1 : bitn;
  wire            lost    = !sda_oe && !sda_in &&
                            ((op == OP_STOP) ||
                             (op == OP_WR && bitn < 4'd8) ||
                             (op == OP_RD && bitn == 4'd8));

  assign cmd_ready = !run;
  assign busy      = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      op       <= OP_START;
      q        <= 2'd0;
      bitn     <= 4'd0;
      dcnt     <= '0;
      wbuf     <= 8'h00;
      shf      <= 8'h00;
      rnack    <= 1'b0;
      done     <= 1'b0;
      ack_nack <= 1'b0;
      rdata    <= 8'h00;
      arb_lost <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (cmd_valid) begin
          run      <= 1'b1;
          op       <= cmd_op;
          wbuf     <= cmd_wdata;
          rnack    <= cmd_rd_nack;
          q        <= 2'd0;
          bitn     <= 4'd0;
          dcnt     <= '0;
          arb_lost <= 1'b0;
          case (cmd_op)
            OP_START: sda_oe <= 1'b0;
            OP_STOP: begin
              scl_oe <= 1'b1;
              sda_oe <= 1'b1;
            end
            default: begin
              scl_oe <= 1'b1;
              sda_oe <= sda_drive(cmd_op, cmd_wdata, cmd_rd_nack, 4'd0);
            end
          endcase
        end
      end else begin
        dcnt <= qtick ? '0 : dcnt + DIVW'(1);
        if (qtick) begin
          if (q == 2'd2 && lost) begin
            run      <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            arb_lost <= 1'b1;
            done     <= 1'b1;
          end else begin
            if (q == 2'd2 && data_op) begin
              if (bitn < 4'd8) shf <= {shf[6:0], sda_in};
              else if (op == OP_WR) ack_nack <= sda_in;
            end
            if (last_q) begin
              run  <= 1'b0;
              done <= 1'b1;
              if (op != OP_STOP) scl_oe <= 1'b1;
              if (op == OP_RD) rdata <= shf;
            end else begin
              q    <= nq;
              bitn <= nb;
              case (op)
                OP_START:
                  case (nq)
                    2'd1:    scl_oe <= 1'b0;
                    2'd2:    sda_oe <= 1'b1;
                    2'd3:    scl_oe <= 1'b1;
                    default: ;
                  endcase
                OP_STOP:
                  case (nq)
                    2'd1:    scl_oe <= 1'b0;
                    2'd2:    sda_oe <= 1'b0;
                    default: ;
                  endcase
                default:
                  case (nq)
                    2'd0: begin
                      scl_oe <= 1'b1;
                      sda_oe <= sda_drive(op, wbuf, rnack, nb);
                    end
                    2'd2:    scl_oe <= 1'b0;
                    default: ;
                  endcase
              endcase
            end
          end
        end
      end
    end
  end

  assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_STOP && !arb_lost) |-> (!scl_oe && !sda_oe));

  assert_start_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_START && $rose(sda_oe)) |-> !scl_oe);

  assert_stop_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_STOP && $fell(sda_oe)) |-> !scl_oe);

  assert_sda_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && data_op && !$past(scl_oe) && !scl_oe) |-> $stable(sda_oe));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe && done));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [3:0] quarter_div;
  logic       cmd_valid, cmd_ready, cmd_rd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata, rdata;
  logic       busy, done, ack_nack, arb_lost;
  logic       scl_oe, sda_oe, scl_in, sda_in, tgt_low;

  i2c_byte_master #(.DIVW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack), .busy(busy),
    .done(done), .ack_nack(ack_nack), .rdata(rdata), .arb_lost(arb_lost),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in)
  );

  assign scl_in = ~scl_oe;
  assign sda_in = ~(sda_oe | tgt_low);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int cur_op = -1;
  int starts = 0;
  int stops  = 0;
  int viol   = 0;
  logic [1:0] tmode   = 2'd0;
  logic [7:0] tbyte   = 8'h00;
  logic [3:0] arb_bit = 4'd0;
  logic [3:0] idx     = 4'd15;
  logic       quiet   = 1'b0;
  logic       scl_p   = 1'b1;
  logic       sda_p   = 1'b1;
  logic [7:0] cap     = 8'h00;
  logic       ack_seen = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  assign tgt_low = (tmode == 2'd1 && idx == 4'd8) ||
                   (tmode == 2'd2 && !quiet && idx < 4'd8 && !tbyte[3'(7 - idx)]) ||
                   (tmode == 2'd3 && idx == arb_bit);

  always @(posedge clk) begin
    scl_p <= scl_in;
    sda_p <= sda_in;
    if (scl_in && scl_p && sda_p && !sda_in) begin
      idx    <= 4'd15;
      quiet  <= 1'b0;
      starts <= starts + 1;
    end
    if (scl_in && scl_p && !sda_p && sda_in) stops <= stops + 1;
    if (scl_p && !scl_in) idx <= (idx == 4'd8 || idx == 4'd15) ? 4'd0 : idx + 4'd1;
    if (!scl_p && scl_in) begin
      if (idx < 4'd8) cap <= {cap[6:0], sda_in};
      else if (idx == 4'd8) begin
        ack_seen <= sda_in;
        if (tmode == 2'd2 && sda_in) quiet <= 1'b1;
      end
    end
    if (scl_in && scl_p && (sda_p != sda_in) && (cur_op == 1 || cur_op == 2)) viol <= viol + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input logic [7:0] d, input logic nk, output int dur);
    int t0, n;
    @(negedge clk);
    cmd_op = 2'(op); cmd_wdata = d; cmd_rd_nack = nk; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    t0 = cyc;
    cur_op = op;
    chk("R11 ready low while busy", {cmd_ready, busy}, 2'b01);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    dur = cyc - t0;
    cur_op = -1;
    @(negedge clk);
    chk("R11 done single cycle", done, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset lines", {scl_oe, sda_oe}, 2'b00);
    chk("R1 reset status", {cmd_ready, busy, done, arb_lost}, 4'b1000);
  endtask

  task automatic t_write_ack;
    int dur, s0, p0;
    quarter_div = 4'd3; tmode = 2'd1;
    s0 = starts; p0 = stops;
    issue(0, 8'h00, 1'b0, dur);
    chk("R2 start length", dur, 12);
    chk("R2 start seen", starts - s0, 1);
    chk("R2 scl held low after start", {scl_oe, sda_oe}, 2'b11);
    issue(1, 8'hA5, 1'b0, dur);
    chk("R5 write length", dur, 108);
    chk("R5 msb first byte", cap, 8'hA5);
    chk("R6 ack reported", ack_nack, 1'b0);
    issue(3, 8'h00, 1'b0, dur);
    chk("R3 stop length", dur, 12);
    chk("R3 stop seen", stops - p0, 1);
    chk("R1 idle after stop", {scl_oe, sda_oe, cmd_ready}, 3'b001);
    chk("R4 no sda change in high", viol, 0);
  endtask

  task automatic t_write_nack;
    int dur;
    quarter_div = 4'd1; tmode = 2'd0;
    issue(0, 8'h00, 1'b0, dur);
    chk("R10 start length div1", dur, 4);
    issue(1, 8'h3C, 1'b0, dur);
    chk("R10 write length div1", dur, 36);
    chk("R5 second byte", cap, 8'h3C);
    chk("R6 nack reported", ack_nack, 1'b1);
    issue(3, 8'h00, 1'b0, dur);
    chk("R4 no sda change in high", viol, 0);
  endtask

  task automatic t_read;
    int dur;
    quarter_div = 4'd2; tmode = 2'd2; tbyte = 8'h96;
    issue(0, 8'h00, 1'b0, dur);
    issue(2, 8'hFF, 1'b0, dur);
    chk("R7 read byte one", rdata, 8'h96);
    chk("R8 ack driven", ack_seen, 1'b0);
    tbyte = 8'h4B;
    issue(2, 8'hFF, 1'b1, dur);
    chk("R7 read byte two", rdata, 8'h4B);
    chk("R8 nack released", ack_seen, 1'b1);
    issue(3, 8'h00, 1'b0, dur);
    chk("R7 rdata held past stop", rdata, 8'h4B);
    chk("R1 idle after read stop", {scl_oe, sda_oe, sda_in}, 3'b001);
    chk("R4 no sda change in high", viol, 0);
  endtask

  task automatic t_arb;
    int dur;
    quarter_div = 4'd2; tmode = 2'd0;
    issue(0, 8'h00, 1'b0, dur);
    tmode = 2'd3; arb_bit = 4'd2;
    issue(1, 8'hFF, 1'b0, dur);
    chk("R9 loss flagged", arb_lost, 1'b1);
    chk("R9 lost at bit two", dur, 22);
    chk("R9 lines released", {scl_oe, sda_oe}, 2'b00);
    tmode = 2'd0;
    issue(0, 8'h00, 1'b0, dur);
    chk("R9 flag cleared by next command", arb_lost, 1'b0);
    issue(3, 8'h00, 1'b0, dur);
    chk("R1 idle after recovery", {scl_oe, sda_oe}, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_wdata = 8'h00;
    cmd_rd_nack = 1'b0; quarter_div = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write_ack;
    t_write_nack;
    t_read;
    t_arb;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule